// File: doc/BRIEF.md
# Double-Buffered Continuous Serial Transmitter

This block is a clocked serial master that sends fixed eight-bit frames, most significant bit first, on a serial clock and a serial data line. The serial clock is derived from the system clock by a fixed division (four by default). A bus-side write port accepts one byte per cycle. A single holding register sits in front of the shift register, so software can queue the next byte while the current one is still being shifted out.

Whenever a byte moves into the shift register, the block raises a one-cycle buffer-free pulse, telling software the holding register may be refilled. If the next byte is written before the current frame finishes, including in the frame's final system cycle, the next frame follows with no idle serial-clock period. If nothing is waiting when the frame ends, the serial clock parks high and the busy flag drops. The transmit enable may be cleared only while the busy flag reads 0.

Top module: `burst_serial_tx`

## Requirements
- R1: A write accepted while idle (wr_valid=1 and tx_en=1 at a clock edge with busy=0) gives, right after that edge, busy=1, sclk=0 and sdo equal to bit 7 of the written byte.
- R2: Bits leave MSB first. sdo changes only in the cycle where sclk falls, so a receiver sampling sdo on each rising edge of sclk recovers the written bytes in order.
- R3: Each frame carries exactly 8 bits, giving 8 rising edges of sclk per frame and 32 system cycles of busy=1 per frame at the default division.
- R4: Within a frame, and across chained frames, sclk has a period of 4 system cycles: 2 cycles low followed by 2 cycles high.
- R5: buf_free is a one-cycle pulse, raised in the cycle right after a byte is loaded into the shift register (at an idle start and at every chained handoff), and only while busy=1.
- R6: A byte written before the current frame ends, including in the final system cycle of the frame, starts the next frame immediately. busy stays 1 throughout, and sclk falls with the new bit 7 on sdo right after the frame boundary.
- R7: If no byte is waiting when a frame ends, busy goes to 0, sclk rests at 1 and sdo keeps the frame's last bit (bit 0).
- R8: A write while a byte is already waiting replaces the waiting byte. The frame being shifted is not disturbed, and only the newest queued byte is sent next.
- R9: A write with tx_en=0 is ignored: busy stays 0, sclk stays 1, no buf_free pulse occurs and no frame is sent.
- R10: While rst_n is low at a clock edge, the block returns to idle: busy=0, buf_free=0, sclk=1, sdo=0, holding register empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit enable; gates write acceptance |
| wr_valid | input | 1 | Write strobe for transmit data |
| wr_data | input | DATA_W | Byte to transmit |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data, changes on the falling edge of sclk |
| buf_free | output | 1 | One-cycle pulse: holding register may be refilled |
| busy | output | 1 | High while a frame is being shifted |

## Verification
A wrong phase counter shows up within one bit time as a serial clock whose period or duty differs from 2 low, 2 high, or as a data change away from a falling edge. A wrong bit counter or a lost holding-register valid flag shows at the frame boundary, at most 32 cycles after the fault, as a busy period of the wrong length, a gap between chained frames, a missing or doubled buffer-free pulse, or a wrong byte at the bit-level receiver model. Overwrite and last-cycle handoff are driven at exact cycle offsets, so a wrong priority between handoff and write shows in the next frame's content.

// File: rtl/bst_pkg.sv
package bst_pkg;

    // Control state of the top-level sequencer
    typedef struct packed {
        logic busy;
        logic sclk;
        logic pulse;
    } bst_ctrl_t;

endpackage

// File: rtl/bst_phase.sv
// Divides the system clock into serial-bit slots; ticks at mid-bit and end-of-bit.
module bst_phase #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mid_tick,
    output logic end_tick
);
    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } ph_state_t;

    ph_state_t st_d, st_q;

    assign mid_tick = run && (st_q.ph == PH_W'(DIV/2 - 1));
    assign end_tick = run && (st_q.ph == PH_W'(DIV - 1));

    always_comb begin
        st_d = st_q;
        if (!run || end_tick) begin
            st_d.ph = '0;
        end else begin
            st_d.ph = st_q.ph + PH_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bst_holdbuf.sv
// Single-entry holding register; a write overwrites a waiting byte.
module bst_holdbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              vld,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } hb_state_t;

    hb_state_t st_d, st_q;

    assign vld  = st_q.vld;
    assign data = st_q.data;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.vld  = 1'b1;
            st_d.data = wr_data;
        end else if (take) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bst_shifter.sv
// MSB-first shift register with bit counter; sdo is the register's top bit.
module bst_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              sdo,
    output logic              last
);
    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
    } sh_state_t;

    sh_state_t st_d, st_q;

    assign sdo  = st_q.sr[DATA_W-1];
    assign last = (st_q.cnt == CNT_W'(DATA_W - 1));

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sr  = load_data;
            st_d.cnt = '0;
        end else if (shift) begin
            st_d.sr  = {st_q.sr[DATA_W-2:0], 1'b0};
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/burst_serial_tx.sv
module burst_serial_tx
    import bst_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sclk,
    output logic              sdo,
    output logic              buf_free,
    output logic              busy
);
    bst_ctrl_t ctl_d, ctl_q;

    logic              mid_tick, end_tick;
    logic              last_bit;
    logic              hold_vld;
    logic [DATA_W-1:0] hold_data;

    logic              accept, frame_end, start_idle, chain_hold, chain_bypass;
    logic              load, hold_wr, shift;
    logic [DATA_W-1:0] load_data;

    // Handoff decode
    always_comb begin
        accept       = wr_valid && tx_en;
        frame_end    = ctl_q.busy && end_tick && last_bit;
        start_idle   = !ctl_q.busy && accept;
        chain_hold   = frame_end && hold_vld;
        chain_bypass = frame_end && !hold_vld && accept;
        load         = start_idle || chain_hold || chain_bypass;
        load_data    = chain_hold ? hold_data : wr_data;
        hold_wr      = accept && !start_idle && !chain_bypass;
        shift        = ctl_q.busy && end_tick && !last_bit;
    end

    // Sequencer next state
    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.pulse = load;
        if (load) begin
            ctl_d.busy = 1'b1;
            ctl_d.sclk = 1'b0;
        end else if (frame_end) begin
            ctl_d.busy = 1'b0;
            ctl_d.sclk = 1'b1;
        end else if (ctl_q.busy && end_tick) begin
            ctl_d.sclk = 1'b0;
        end else if (ctl_q.busy && mid_tick) begin
            ctl_d.sclk = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{busy: 1'b0, sclk: 1'b1, pulse: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    bst_phase #(.DIV(DIV)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctl_q.busy),
        .mid_tick (mid_tick),
        .end_tick (end_tick)
    );

    bst_holdbuf #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (hold_wr),
        .wr_data (wr_data),
        .take    (chain_hold),
        .vld     (hold_vld),
        .data    (hold_data)
    );

    bst_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (load_data),
        .shift     (shift),
        .sdo       (sdo),
        .last      (last_bit)
    );

    assign sclk     = ctl_q.sclk;
    assign busy     = ctl_q.busy;
    assign buf_free = ctl_q.pulse;
endmodule

// File: rtl/burst_serial_tx_chk.sv
module burst_serial_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic wr_valid,
    input logic sclk,
    input logic sdo,
    input logic buf_free,
    input logic busy
);
    AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_valid && tx_en) |=> (busy && !sclk && buf_free)); // R1

    AST_SDO_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdo)); // R2

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_free |=> !buf_free); // R5

    AST_PULSE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        buf_free |-> busy); // R5

    AST_IDLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk); // R7

    AST_NO_WRITE_STAY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(wr_valid && tx_en)) |=> !busy); // R9
endmodule

bind burst_serial_tx burst_serial_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .wr_valid (wr_valid),
    .sclk     (sclk),
    .sdo      (sdo),
    .buf_free (buf_free),
    .busy     (busy)
);

// File: tb/burst_serial_tx_tb.sv
`timescale 1ns/1ps
module burst_serial_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sclk, sdo, buf_free, busy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    burst_serial_tx u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_valid(wr_valid),
        .wr_data(wr_data), .sclk(sclk), .sdo(sdo), .buf_free(buf_free), .busy(busy)
    );

    // Receiver model and line monitor, sampled on the falling edge of clk
    logic [7:0] rx_bytes [0:31];
    int   rx_n = 0, rx_bits = 0;
    logic [7:0] rx_sr = 8'h00;
    int   rises = 0, pulses = 0, busy_cyc = 0, busy_falls = 0;
    int   period_err = 0, sdo_err = 0, pulse_err = 0;
    int   cyc = 0, last_rise = 0;
    bit   rise_ok = 1'b0;
    logic p_sclk = 1'b1, p_sdo = 1'b0, p_busy = 1'b0, p_pulse = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (sclk && !p_sclk) begin
                rises++;
                rx_sr = {rx_sr[6:0], sdo};
                rx_bits++;
                if (rx_bits == 8) begin
                    if (rx_n < 32) rx_bytes[rx_n] = rx_sr;
                    rx_n++;
                    rx_bits = 0;
                end
                if (rise_ok && (cyc - last_rise) != 4) period_err++;
                last_rise = cyc;
                rise_ok = 1'b1;
            end
            if (sclk && !p_sclk && busy && !p_busy) period_err++;
            if ((sdo !== p_sdo) && !(p_sclk && !sclk)) sdo_err++;
            if (busy) busy_cyc++;
            if (!busy) rise_ok = 1'b0;
            if (!busy && p_busy) busy_falls++;
            if (buf_free) pulses++;
            if (buf_free && p_pulse) pulse_err++;
        end
        p_sclk = sclk; p_sdo = sdo; p_busy = busy; p_pulse = buf_free;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Caller is at a falling edge of clk; returns at the falling edge after the accepting edge.
    task automatic write_byte(input logic [7:0] d);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(busy == 1'b0,     "R10 busy", busy, 0);
        check(sclk == 1'b1,     "R10 sclk", sclk, 1);
        check(sdo == 1'b0,      "R10 sdo", sdo, 0);
        check(buf_free == 1'b0, "R10 buf_free", buf_free, 0);
    endtask

    task automatic t_single();
        int b_rx = rx_n, b_r = rises, b_p = pulses, b_bc = busy_cyc;
        @(negedge clk);
        write_byte(8'hA5);
        check(busy == 1'b1,     "R1 busy after write", busy, 1);
        check(sclk == 1'b0,     "R1 sclk low at start", sclk, 0);
        check(sdo == 1'b1,      "R1 first bit is bit7", sdo, 1);
        check(buf_free == 1'b1, "R5 pulse at idle load", buf_free, 1);
        wait_idle();
        check(rx_n - b_rx == 1, "R2 one byte received", rx_n - b_rx, 1);
        check(rx_bytes[b_rx] == 8'hA5, "R2 byte MSB first", rx_bytes[b_rx], 8'hA5);
        check(rises - b_r == 8, "R3 eight sclk rises", rises - b_r, 8);
        check(busy_cyc - b_bc == 32, "R3 busy length", busy_cyc - b_bc, 32);
        check(pulses - b_p == 1, "R5 one pulse", pulses - b_p, 1);
        check(sclk == 1'b1 && busy == 1'b0, "R7 idle sclk high busy low", {sclk, busy}, 2'b10);
        check(sdo == 1'b1,      "R7 sdo holds bit0", sdo, 1);
    endtask

    task automatic t_chain();
        int b_rx = rx_n, b_p = pulses, b_bc = busy_cyc, b_f = busy_falls, b_r = rises;
        @(negedge clk);
        write_byte(8'h3C);
        repeat (5) @(negedge clk);
        write_byte(8'hC3);
        wait_idle();
        check(rx_n - b_rx == 2, "R6 two bytes chained", rx_n - b_rx, 2);
        check(rx_bytes[b_rx] == 8'h3C, "R2 chain byte0", rx_bytes[b_rx], 8'h3C);
        check(rx_bytes[b_rx+1] == 8'hC3, "R2 chain byte1", rx_bytes[b_rx+1], 8'hC3);
        check(busy_cyc - b_bc == 64, "R6 no gap busy cycles", busy_cyc - b_bc, 64);
        check(busy_falls - b_f == 1, "R6 busy never dropped", busy_falls - b_f, 1);
        check(pulses - b_p == 2, "R5 pulse per handoff", pulses - b_p, 2);
        check(rises - b_r == 16, "R3 sixteen rises", rises - b_r, 16);
    endtask

    task automatic t_overwrite();
        int b_rx = rx_n, b_bc = busy_cyc, b_p = pulses;
        @(negedge clk);
        write_byte(8'h11);
        repeat (3) @(negedge clk);
        write_byte(8'h22);
        repeat (4) @(negedge clk);
        write_byte(8'h33);
        wait_idle();
        check(rx_n - b_rx == 2, "R8 two frames sent", rx_n - b_rx, 2);
        check(rx_bytes[b_rx] == 8'h11, "R8 current frame intact", rx_bytes[b_rx], 8'h11);
        check(rx_bytes[b_rx+1] == 8'h33, "R8 newest byte sent", rx_bytes[b_rx+1], 8'h33);
        check(busy_cyc - b_bc == 64, "R8 frame count", busy_cyc - b_bc, 64);
        check(pulses - b_p == 2, "R8 pulses", pulses - b_p, 2);
    endtask

    task automatic t_last_cycle();
        int b_rx = rx_n, b_bc = busy_cyc, b_f = busy_falls;
        @(negedge clk);
        write_byte(8'h5A);
        repeat (31) @(negedge clk);
        write_byte(8'hA7);
        check(busy == 1'b1,     "R6 busy across boundary", busy, 1);
        check(sclk == 1'b0,     "R6 sclk falls at boundary", sclk, 0);
        check(sdo == 1'b1,      "R6 new bit7 on sdo", sdo, 1);
        check(buf_free == 1'b1, "R5 pulse at boundary", buf_free, 1);
        wait_idle();
        check(busy_cyc - b_bc == 64, "R6 last-cycle chain no gap", busy_cyc - b_bc, 64);
        check(busy_falls - b_f == 1, "R6 single busy fall", busy_falls - b_f, 1);
        check(rx_bytes[b_rx] == 8'h5A && rx_bytes[b_rx+1] == 8'hA7, "R2 last-cycle bytes",
              {rx_bytes[b_rx], rx_bytes[b_rx+1]}, 16'h5AA7);
        check(sdo == 1'b1,      "R7 sdo holds bit0 of A7", sdo, 1);
    endtask

    task automatic t_disabled();
        int b_rx = rx_n, b_p = pulses, b_bc = busy_cyc;
        @(negedge clk);
        tx_en = 1'b0;
        write_byte(8'h77);
        check(busy == 1'b0, "R9 busy stays low", busy, 0);
        repeat (40) @(negedge clk);
        check(sclk == 1'b1, "R9 sclk stays high", sclk, 1);
        check(pulses - b_p == 0, "R9 no pulse", pulses - b_p, 0);
        check(rx_n - b_rx == 0 && busy_cyc - b_bc == 0, "R9 no frame", rx_n - b_rx, 0);
        tx_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_chain();
        t_overwrite();
        t_last_cycle();
        t_disabled();
        check(period_err == 0, "R4 sclk period 4", period_err, 0);
        check(sdo_err == 0,    "R2 sdo changes only on sclk fall", sdo_err, 0);
        check(pulse_err == 0,  "R5 pulse one cycle", pulse_err, 0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x%0h expected=0x%0h", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule